// File: doc/BRIEF.md
# Stream Error Flush and Reset Sequencer

This block sits on a ready/valid byte stream between a source and a configuration-loading controller. It watches the controller's 3-bit status output. While the status is healthy, the block is transparent: ready flows back to the source, and valid and data flow forward to the controller. When the controller reports a load error, it stops accepting data and cannot take more until it is reset. Resetting it at once would leave words of the corrupt stream stuck in the upstream pipeline.

The sequencer handles this. On the error code it takes the upstream handshake over and holds ready high, so the rest of the stream drains and is discarded. The controller sees no valid during this phase. The block waits until the source has kept valid low for a set number of consecutive cycles. It then pulses an active-high reset to the controller for a set number of cycles and spends one settling cycle. After that it returns to transparent operation, raises a sticky completion flag, and the source may send a fresh stream.

Top module: `flush_reset_seq`

## Requirements
- R1: In pass-through mode `up_ready` equals `dn_ready`, `dn_valid` equals `up_valid`, `dn_data` equals `up_data`, and `ctl_reset` and `busy` are low.
- R2: Only the status value 3'b100 on `ctl_status` starts recovery. It is sampled on a clock edge in pass-through mode, and `busy` is high from the next cycle. Every other status code leaves the block in pass-through mode.
- R3: While draining, `up_ready` is high, `dn_valid` is low, `dn_data` is all zeros and `ctl_reset` is low, whatever the inputs are.
- R4: `ctl_reset` rises only after `IDLE_CYCLES` (default 16) consecutive clock edges in the drain phase with `up_valid` low. Any edge with `up_valid` high restarts that count from zero.
- R5: `ctl_reset` stays high for exactly `RST_CYCLES` (default 4) cycles. During those cycles `up_ready` and `dn_valid` are low.
- R6: After `ctl_reset` falls, there is exactly one settling cycle with `busy` high and all stream outputs blocked. Pass-through mode follows it.
- R7: Changes on `ctl_status` during the drain phase and the reset pulse have no effect. This includes a return to a healthy code and a repeated error code.
- R8: `recovered` goes high in the first pass-through cycle after a completed sequence. It stays high until `recovered_clr` is high on a clock edge. If both happen on the same edge, setting wins.
- R9: `busy` is high in the drain, reset and settling phases, and low only in pass-through mode.
- R10: A synchronous `rst` returns the block to pass-through mode within one edge. After that edge `ctl_reset`, `busy` and `recovered` are low, and the drain count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Source valid |
| up_data | input | DATA_W | Source data |
| up_ready | output | 1 | Ready to source |
| dn_valid | output | 1 | Valid to controller |
| dn_data | output | DATA_W | Data to controller |
| dn_ready | input | 1 | Controller ready |
| ctl_status | input | 3 | Controller status, 3'b100 means error |
| ctl_reset | output | 1 | Active-high reset pulse to controller |
| busy | output | 1 | High outside pass-through mode |
| recovered | output | 1 | Sticky completion flag |
| recovered_clr | input | 1 | Write-one-to-clear for `recovered` |

## Verification
The bench raises a single valid-high word in the middle of the quiet window. A sequencer that does not restart its idle count would then pulse the reset several cycles too early. The bench also drops the error status back to healthy during the drain and raises it again during the reset pulse. A design that listened to status in those phases would abort the drain or retrigger. It times the pulse and the settling cycle to the exact edge, which catches a counter that is off by one. It also raises clear and completion together to show that setting the flag wins over clearing it.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_RESET   = 2'd2,
        ST_RECOVER = 2'd3
    } frs_state_e;

    typedef struct packed {
        frs_state_e state;
        logic       recovered;
    } frs_regs_t;

endpackage

// File: rtl/frs_err_detect.sv
module frs_err_detect #(
    parameter int                  STATUS_W = 3,
    parameter logic [STATUS_W-1:0] ERR_CODE = 3'b100
) (
    input  logic [STATUS_W-1:0] status,
    output logic                err
);

    always_comb begin
        err = (status == ERR_CODE);
    end

endmodule

// File: rtl/frs_run_counter.sv
module frs_run_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic done
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = inc && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear || done) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/frs_stream_mux.sv
module frs_stream_mux #(
    parameter int DATA_W = 8
) (
    input  logic              pass,
    input  logic              drain,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    input  logic              dn_ready,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data
);

    always_comb begin
        if (pass) begin
            up_ready = dn_ready;
            dn_valid = up_valid;
            dn_data  = up_data;
        end else begin
            up_ready = drain;
            dn_valid = 1'b0;
            dn_data  = '0;
        end
    end

endmodule

// File: rtl/flush_reset_seq.sv
module flush_reset_seq #(
    parameter int DATA_W      = 8,
    parameter int IDLE_CYCLES = 16,
    parameter int RST_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ready,
    input  logic [2:0]        ctl_status,
    output logic              ctl_reset,
    output logic              busy,
    output logic              recovered,
    input  logic              recovered_clr
);

    import frs_pkg::*;

    frs_regs_t r_d, r_q;
    frs_state_e state_q;

    logic err_seen;
    logic in_drain, in_reset, in_pass;
    logic quiet_done, pulse_done;

    assign state_q  = r_q.state;
    assign in_pass  = (r_q.state == ST_PASS);
    assign in_drain = (r_q.state == ST_DRAIN);
    assign in_reset = (r_q.state == ST_RESET);

    frs_err_detect #(
        .STATUS_W (3),
        .ERR_CODE (3'b100)
    ) u_err (
        .status (ctl_status),
        .err    (err_seen)
    );

    frs_run_counter #(
        .LIMIT (IDLE_CYCLES)
    ) u_quiet (
        .clk   (clk),
        .rst   (rst),
        .clear (!in_drain || up_valid),
        .inc   (in_drain && !up_valid),
        .done  (quiet_done)
    );

    frs_run_counter #(
        .LIMIT (RST_CYCLES)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .clear (!in_reset),
        .inc   (in_reset),
        .done  (pulse_done)
    );

    frs_stream_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .pass     (in_pass),
        .drain    (in_drain),
        .up_valid (up_valid),
        .up_data  (up_data),
        .dn_ready (dn_ready),
        .up_ready (up_ready),
        .dn_valid (dn_valid),
        .dn_data  (dn_data)
    );

    always_comb begin
        r_d = r_q;
        if (recovered_clr) begin
            r_d.recovered = 1'b0;
        end
        unique case (r_q.state)
            ST_PASS: begin
                if (err_seen) begin
                    r_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (quiet_done) begin
                    r_d.state = ST_RESET;
                end
            end
            ST_RESET: begin
                if (pulse_done) begin
                    r_d.state = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                r_d.state     = ST_PASS;
                r_d.recovered = 1'b1;
            end
            default: r_d.state = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_PASS, recovered: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_reset = in_reset;
    assign busy      = !in_pass;
    assign recovered = r_q.recovered;

endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
    parameter int IDLE_CYCLES = 16,
    parameter int RST_CYCLES  = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 up_valid,
    input logic                 up_ready,
    input logic                 dn_valid,
    input logic                 dn_ready,
    input logic [2:0]           ctl_status,
    input logic                 ctl_reset,
    input logic                 busy,
    input logic                 recovered,
    input logic                 recovered_clr,
    input frs_pkg::frs_state_e  state_q
);

    import frs_pkg::*;

    int quiet_run;
    int pulse_run;

    always_ff @(posedge clk) begin
        if (rst || up_valid) begin
            quiet_run <= 0;
        end else if (quiet_run < IDLE_CYCLES) begin
            quiet_run <= quiet_run + 1;
        end
        if (rst || !ctl_reset) begin
            pulse_run <= 0;
        end else if (pulse_run < RST_CYCLES + 1) begin
            pulse_run <= pulse_run + 1;
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (up_ready == dn_ready && dn_valid == up_valid && !ctl_reset)); // R1
    AST_ERR_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctl_status == 3'b100) |=> busy); // R2
    AST_OK_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctl_status != 3'b100) |=> !busy); // R2
    AST_DRAIN_SWALLOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN) |-> (up_ready && !dn_valid && !ctl_reset)); // R3
    AST_QUIET_BEFORE_RESET: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_reset) |-> (quiet_run >= IDLE_CYCLES)); // R4
    AST_PULSE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |-> (!up_ready && !dn_valid)); // R5
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_reset) |-> (pulse_run == RST_CYCLES)); // R5
    AST_SETTLE_ONE: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_reset) |-> (busy ##1 !busy)); // R6
    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && up_valid) |=> (state_q == ST_DRAIN)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (recovered && !recovered_clr) |=> recovered); // R8
    AST_BUSY_STATE: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |-> busy); // R9

endmodule

bind flush_reset_seq frs_checker #(
    .IDLE_CYCLES (IDLE_CYCLES),
    .RST_CYCLES  (RST_CYCLES)
) u_frs_checker (
    .clk           (clk),
    .rst           (rst),
    .up_valid      (up_valid),
    .up_ready      (up_ready),
    .dn_valid      (dn_valid),
    .dn_ready      (dn_ready),
    .ctl_status    (ctl_status),
    .ctl_reset     (ctl_reset),
    .busy          (busy),
    .recovered     (recovered),
    .recovered_clr (recovered_clr),
    .state_q       (state_q)
);

// File: tb/test_flush_reset_seq.sv
module test_flush_reset_seq;

    localparam int DATA_W = 8;
    localparam int IDLE   = 16;
    localparam int RSTC   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              up_valid = 1'b0;
    logic [DATA_W-1:0] up_data = '0;
    logic              up_ready;
    logic              dn_valid;
    logic [DATA_W-1:0] dn_data;
    logic              dn_ready = 1'b0;
    logic [2:0]        ctl_status = 3'b000;
    logic              ctl_reset;
    logic              busy;
    logic              recovered;
    logic              recovered_clr = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    flush_reset_seq #(
        .DATA_W      (DATA_W),
        .IDLE_CYCLES (IDLE),
        .RST_CYCLES  (RSTC)
    ) i_flush_reset_seq (
        .clk           (clk),
        .rst           (rst),
        .up_valid      (up_valid),
        .up_data       (up_data),
        .up_ready      (up_ready),
        .dn_valid      (dn_valid),
        .dn_data       (dn_data),
        .dn_ready      (dn_ready),
        .ctl_status    (ctl_status),
        .ctl_reset     (ctl_reset),
        .busy          (busy),
        .recovered     (recovered),
        .recovered_clr (recovered_clr)
    );

    // stimulus {status, valid, data, ready} then expected {up_ready, dn_valid, dn_data}
    localparam int VW = 3 + 1 + 8 + 1 + 1 + 1 + 8;
    localparam logic [VW-1:0] VECS [8] = '{
        {3'b000, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b1, 8'hA5},
        {3'b001, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 8'h3C},
        {3'b010, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 8'hFF},
        {3'b011, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
        {3'b101, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1, 8'h81},
        {3'b110, 1'b1, 8'h7E, 1'b0, 1'b0, 1'b1, 8'h7E},
        {3'b111, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b0, 8'h5A},
        {3'b000, 1'b1, 8'h12, 1'b0, 1'b0, 1'b1, 8'h12}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance to the next falling edge, then let inputs settle
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic drain_outputs(input string req);
        chk({req, " up_ready"}, up_ready, 1);
        chk({req, " dn_valid"}, dn_valid, 0);
        chk({req, " dn_data"}, dn_data, 0);
        chk({req, " busy"}, busy, 1);
    endtask

    // enter drain from pass with valid low, then expect the pulse after IDLE quiet edges
    task automatic run_sequence(input bit clr_at_end);
        ctl_status = 3'b100;
        up_valid   = 1'b0;
        tick();
        ctl_status = 3'b000;
        for (int i = 0; i < IDLE - 1; i++) tick();
        chk("R4 no early pulse", ctl_reset, 0);
        tick();
        chk("R5 pulse begins", ctl_reset, 1);
        for (int i = 0; i < RSTC - 1; i++) tick();
        chk("R5 pulse last cycle", ctl_reset, 1);
        recovered_clr = clr_at_end;
        tick();
        chk("R6 settle low reset", ctl_reset, 0);
        chk("R6 settle busy", busy, 1);
        tick();
        recovered_clr = 1'b0;
        chk("R6 back to pass", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset ctl_reset", ctl_reset, 0);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset recovered", recovered, 0);
        rst = 1'b0;
        tick();

        // R1 and R2: pass-through under healthy codes
        for (int v = 0; v < 8; v++) begin
            logic [VW-1:0] row;
            row        = VECS[v];
            ctl_status = row[VW-1 -: 3];
            up_valid   = row[VW-4];
            up_data    = row[VW-5 -: 8];
            dn_ready   = row[VW-13];
            #1;
            chk("R1 up_ready", up_ready, row[VW-14]);
            chk("R1 dn_valid", dn_valid, row[VW-15]);
            chk("R1 dn_data", dn_data, row[7:0]);
            chk("R1 ctl_reset", ctl_reset, 0);
            tick();
            chk("R2 healthy code stays", busy, 0);
        end

        // R2, R3, R7, R4: error with trailing words, status changes ignored
        dn_ready   = 1'b0;
        up_valid   = 1'b1;
        up_data    = 8'hC3;
        ctl_status = 3'b100;
        #1;
        chk("R2 still pass before edge", busy, 0);
        tick();
        drain_outputs("R3 drain entry");
        chk("R9 busy in drain", busy, 1);
        ctl_status = 3'b000;
        for (int i = 0; i < 5; i++) begin
            up_data = 8'(i + 16);
            tick();
            drain_outputs("R7 drain after healthy status");
        end
        up_valid = 1'b0;
        for (int i = 0; i < 8; i++) tick();
        chk("R4 partial quiet", ctl_reset, 0);
        up_valid = 1'b1;
        tick();
        up_valid = 1'b0;
        for (int i = 0; i < IDLE - 1; i++) tick();
        chk("R4 count restarted", ctl_reset, 0);
        drain_outputs("R3 drain late");
        tick();
        chk("R4 pulse after quiet", ctl_reset, 1);
        ctl_status = 3'b100;
        chk("R5 up_ready blocked", up_ready, 0);
        chk("R5 dn_valid blocked", dn_valid, 0);
        tick();
        ctl_status = 3'b000;
        for (int i = 0; i < RSTC - 2; i++) tick();
        chk("R7 R5 pulse still high", ctl_reset, 1);
        tick();
        chk("R6 settle", ctl_reset, 0);
        chk("R9 busy settle", busy, 1);
        chk("R8 flag not yet", recovered, 0);
        tick();
        chk("R6 pass resumed", busy, 0);
        chk("R8 flag set", recovered, 1);
        tick();
        chk("R8 flag sticky", recovered, 1);
        recovered_clr = 1'b1;
        tick();
        recovered_clr = 1'b0;
        chk("R8 flag cleared", recovered, 0);

        // R8: set wins over clear on the same edge
        run_sequence(1'b1);
        chk("R8 set beats clear", recovered, 1);
        recovered_clr = 1'b1;
        tick();
        recovered_clr = 1'b0;
        chk("R8 clear after", recovered, 0);

        // R10: reset mid-drain
        ctl_status = 3'b100;
        tick();
        ctl_status = 3'b000;
        chk("R10 precondition busy", busy, 1);
        for (int i = 0; i < 10; i++) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R10 busy cleared", busy, 0);
        chk("R10 ctl_reset low", ctl_reset, 0);
        dn_ready = 1'b1;
        #1;
        chk("R10 R1 pass after reset", up_ready, 1);
        // drain count must start from zero after reset
        run_sequence(1'b0);
        chk("R10 R8 flag after fresh run", recovered, 1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule